// File: doc/BRIEF.md
# Diversity Antenna Selection Controller

This controller decides which of two receive antennas feeds an FM tuner. It watches a digital lock flag from a subcarrier detector that tracks the 19 kHz stereo pilot. When the flag shows the pilot has been lost, the controller moves to the second antenna. It keeps that antenna as long as lock holds. If lock does not come back within a timeout, it returns to the primary antenna.

A mode input marks reception with no pilot at all, such as AM. While that input is high the primary antenna is always selected. The lock flag may be asynchronous to the controller clock, so it is synchronized first. A loss is confirmed only after the synchronized flag has stayed low for a programmable number of cycles. After a fallback, a hold-off window stops the controller from swapping straight back, so the selection cannot flap.

Top module: `ant_div_ctrl`

## Requirements
- R1: While rst_ni is low and straight after reset, ant_sel_o is 0, where 0 selects the primary antenna and 1 selects the alternate. Reset also clears every timer.
- R2: lock_i passes through a two-flop synchronizer. Lock counts as lost only after LOSS_CYC consecutive low synchronized samples, so a shorter low pulse changes nothing. A confirmed loss first becomes visible 2+LOSS_CYC clock edges after lock_i falls.
- R3: A confirmed loss while the primary is selected and non_fm_i is low sets ant_sel_o to 1 on the next clock edge. Overall, that is 3+LOSS_CYC edges after lock_i falls.
- R4: While lock is confirmed present, the selection does not change.
- R5: On the alternate antenna, ant_sel_o returns to 0 once loss has been confirmed for TIMEOUT_CYC consecutive edges. The default for TIMEOUT_CYC is CLK_HZ/10 cycles, which is 0.1 s.
- R6: After such a fallback, the controller stays on the primary antenna until lock is regained or HOLDOFF_CYC edges have passed. Only then may it swap again.
- R7: ant_sel_o is 0 in any cycle where non_fm_i is high. From the next edge on, the controller rests on the primary antenna with its timers cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| lock_i | input | 1 | Pilot lock flag, high while the detector is locked |
| non_fm_i | input | 1 | High during reception that carries no pilot |
| ant_sel_o | output | 1 | 0 selects the primary antenna, 1 selects the alternate |

## Verification
The bench builds the controller with LOSS_CYC=4, TIMEOUT_CYC=20 and HOLDOFF_CYC=10. With these values, several complete cycles of swap, timeout, hold-off and re-swap fit into a few thousand clocks. At the default values, a single 0.1 s timeout alone would take ten million cycles. The short loss filter lets random lock patterns land close to the filter threshold, both just under it and just over it. The narrow timers let lock come back exactly at the timeout edge and at the hold-off edge.

// File: rtl/ant_div_pkg.sv
package ant_div_pkg;
  typedef enum logic [1:0] {
    SEL_PRI  = 2'd0,
    SEL_ALT  = 2'd1,
    SEL_BACK = 2'd2
  } sel_state_e;
endpackage

// File: rtl/ant_div_sync.sv
module ant_div_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_q <= '0;
    else         q_q <= {q_q[STAGES-2:0], d_i};
  end

  assign q_o = q_q[STAGES-1];
endmodule

// File: rtl/ant_div_loss_filter.sv
module ant_div_loss_filter #(
  parameter int LOSS_CYC = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lock_s_i,
  output logic lost_o
);
  localparam int CNT_W = (LOSS_CYC > 1) ? $clog2(LOSS_CYC + 1) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(LOSS_CYC - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             lost_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      lost_q <= 1'b0;
    end else if (lock_s_i) begin
      cnt_q  <= '0;
      lost_q <= 1'b0;
    end else if (cnt_q == CNT_LAST) begin
      lost_q <= 1'b1;  // saturate, hold count
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign lost_o = lost_q;

  assert_regain_clears_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_s_i |=> !lost_q);
  assert_cnt_bound_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_LAST);
endmodule

// File: rtl/ant_div_sel_fsm.sv
module ant_div_sel_fsm
  import ant_div_pkg::*;
#(
  parameter int TIMEOUT_CYC = 10_000_000,
  parameter int HOLDOFF_CYC = 5_000_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lost_i,
  input  logic non_fm_i,
  output logic ant_sel_o
);
  localparam int TMR_MAX = (TIMEOUT_CYC > HOLDOFF_CYC) ? TIMEOUT_CYC : HOLDOFF_CYC;
  localparam int TMR_W   = $clog2(TMR_MAX + 1);
  localparam logic [TMR_W-1:0] TO_LAST = TMR_W'(TIMEOUT_CYC - 1);
  localparam logic [TMR_W-1:0] HO_LAST = TMR_W'(HOLDOFF_CYC - 1);

  sel_state_e       st_q;
  logic [TMR_W-1:0] tmr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= SEL_PRI;
      tmr_q <= '0;
    end else if (non_fm_i) begin
      st_q  <= SEL_PRI;
      tmr_q <= '0;
    end else begin
      unique case (st_q)
        SEL_PRI: begin
          tmr_q <= '0;
          if (lost_i) st_q <= SEL_ALT;
        end
        SEL_ALT: begin
          if (!lost_i) tmr_q <= '0;
          else if (tmr_q == TO_LAST) begin
            st_q  <= SEL_BACK;
            tmr_q <= '0;
          end else tmr_q <= tmr_q + 1'b1;
        end
        SEL_BACK: begin
          // hold-off: leave early only on regained lock
          if (!lost_i || tmr_q == HO_LAST) begin
            st_q  <= SEL_PRI;
            tmr_q <= '0;
          end else tmr_q <= tmr_q + 1'b1;
        end
        default: begin
          st_q  <= SEL_PRI;
          tmr_q <= '0;
        end
      endcase
    end
  end

  assign ant_sel_o = (st_q == SEL_ALT) && !non_fm_i;

  assert_swap_on_loss_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == SEL_PRI && lost_i && !non_fm_i) |=> st_q == SEL_ALT);
  assert_hold_locked_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!lost_i && !non_fm_i && st_q != SEL_BACK) |=> $stable(st_q));
  assert_timer_bound_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == SEL_ALT) |-> tmr_q <= TO_LAST);
  assert_no_direct_reswap_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == SEL_BACK) |=> st_q != SEL_ALT);
  assert_nonfm_primary_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    non_fm_i |=> (st_q == SEL_PRI && tmr_q == '0));
endmodule

// File: rtl/ant_div_ctrl.sv
module ant_div_ctrl #(
  parameter int CLK_HZ      = 100_000_000,
  parameter int TIMEOUT_CYC = CLK_HZ / 10,
  parameter int LOSS_CYC    = 64,
  parameter int HOLDOFF_CYC = CLK_HZ / 20,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lock_i,
  input  logic non_fm_i,
  output logic ant_sel_o
);
  logic lock_s;
  logic lost;

  ant_div_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (lock_i),
    .q_o   (lock_s)
  );

  ant_div_loss_filter #(.LOSS_CYC(LOSS_CYC)) u_filter (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .lock_s_i(lock_s),
    .lost_o  (lost)
  );

  ant_div_sel_fsm #(
    .TIMEOUT_CYC(TIMEOUT_CYC),
    .HOLDOFF_CYC(HOLDOFF_CYC)
  ) u_fsm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .lost_i   (lost),
    .non_fm_i (non_fm_i),
    .ant_sel_o(ant_sel_o)
  );

  assert_reset_primary_R1: assert property (@(posedge clk_i)
    !rst_ni |-> !ant_sel_o);
endmodule

// File: tb/ant_div_ctrl_tb_top.sv
`timescale 1ns/1ps
module ant_div_ctrl_tb_top;
  localparam int LOSS = 4;
  localparam int TO   = 20;
  localparam int HO   = 10;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic lock_i = 1'b0;
  logic non_fm_i = 1'b0;
  logic ant_sel_o;

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  // reference model state
  bit m_s1, m_s2, m_lost;
  int m_cnt, m_st, m_tmr;  // m_st: 0 primary, 1 alternate, 2 hold-off

  always #2.5 clk = ~clk;

  ant_div_ctrl #(
    .CLK_HZ(1000), .TIMEOUT_CYC(TO), .LOSS_CYC(LOSS), .HOLDOFF_CYC(HO)
  ) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .lock_i(lock_i),
    .non_fm_i(non_fm_i), .ant_sel_o(ant_sel_o)
  );

  function automatic bit exp_sel();
    return (m_st == 1) && !non_fm_i;
  endfunction

  task automatic check(input bit exp, input string tag);
    n_chk++;
    if (ant_sel_o !== exp) begin
      n_err++;
      $display("FAIL %s: ant_sel_o=%b expected=%b at %0t", tag, ant_sel_o, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_s1 = 0; m_s2 = 0; m_lost = 0; m_cnt = 0; m_st = 0; m_tmr = 0;
  endtask

  task automatic model_step();
    bit n_s1, n_s2, n_lost;
    int n_cnt, n_st, n_tmr;
    n_s1 = lock_i; n_s2 = m_s1;
    n_cnt = m_cnt; n_lost = m_lost;
    if (m_s2) begin n_cnt = 0; n_lost = 0; end
    else if (m_cnt == LOSS - 1) n_lost = 1;
    else n_cnt = m_cnt + 1;
    n_st = m_st; n_tmr = m_tmr;
    if (non_fm_i) begin n_st = 0; n_tmr = 0; end
    else if (m_st == 0) begin n_tmr = 0; if (m_lost) n_st = 1; end
    else if (m_st == 1) begin
      if (!m_lost) n_tmr = 0;
      else if (m_tmr == TO - 1) begin n_st = 2; n_tmr = 0; end
      else n_tmr = m_tmr + 1;
    end else begin
      if (!m_lost || m_tmr == HO - 1) begin n_st = 0; n_tmr = 0; end
      else n_tmr = m_tmr + 1;
    end
    m_s1 = n_s1; m_s2 = n_s2; m_cnt = n_cnt; m_lost = n_lost;
    m_st = n_st; m_tmr = n_tmr;
  endtask

  function automatic string tag_now();
    if (non_fm_i) return "R7";
    if (m_st == 1) return "R5";
    if (m_st == 2) return "R6";
    return "R4";
  endfunction

  // one clock: drive at negedge, compare with model, then advance model
  task automatic cyc(input bit lk, input bit nf);
    @(negedge clk);
    lock_i = lk; non_fm_i = nf;
    #1 check(exp_sel(), tag_now());
    @(posedge clk);
    model_step();
  endtask

  task automatic peek(input bit exp, input string tag);
    #1 check(exp, tag);
  endtask

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    check(1'b0, "R1 in reset");
    rst_ni = 1'b1;
    cyc(1, 0);
    peek(1'b0, "R1 after reset");
    repeat (10) cyc(1, 0);
    peek(1'b0, "R4 locked primary");

    // R2: low pulse one cycle short of the filter length is ignored
    repeat (LOSS - 1) cyc(0, 0);
    repeat (LOSS + 6) cyc(1, 0);
    peek(1'b0, "R2 short dip ignored");

    // R3: exact swap latency
    repeat (LOSS + 2) cyc(0, 0);
    peek(1'b0, "R3 before swap edge");
    cyc(0, 0);
    peek(1'b1, "R3 swap edge");

    // R5: alternate held for exactly TO edges of confirmed loss
    repeat (TO - 1) cyc(0, 0);
    peek(1'b1, "R5 before timeout");
    cyc(0, 0);
    peek(1'b0, "R5 timeout fallback");

    // R6: hold-off with lock still missing, then re-swap
    repeat (HO) cyc(0, 0);
    peek(1'b0, "R6 hold-off end");
    cyc(0, 0);
    peek(1'b1, "R6 re-swap after hold-off");

    // R4: lock regained on alternate keeps it
    repeat (TO + 10) cyc(1, 0);
    peek(1'b1, "R4 alternate held");

    // R7: non-FM forces primary immediately
    @(negedge clk);
    non_fm_i = 1'b1;
    #1 check(1'b0, "R7 same cycle");
    @(posedge clk);
    model_step();
    cyc(1, 1);
    cyc(0, 0);
    peek(1'b0, "R7 rests on primary");
    repeat (LOSS + 4) cyc(1, 0);

    // constrained random segments
    void'($urandom(32'h5eed_a17e));
    for (int seg = 0; seg < 400; seg++) begin
      bit lk = $urandom_range(0, 1);
      bit nf = ($urandom_range(0, 15) == 0);
      int len = $urandom_range(1, 2 * LOSS + TO);
      for (int k = 0; k < len; k++) cyc(lk, nf);
    end

    // reset mid-operation
    @(negedge clk);
    rst_ni = 1'b0;
    #1 check(1'b0, "R1 async reset");
    model_reset();
    @(negedge clk);
    rst_ni = 1'b1;
    repeat (5) cyc(1, 0);
    peek(1'b0, "R1 post re-reset");

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      n_err++;
      n_chk++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule